// File: doc/BRIEF.md
# General-Purpose Up-Counting Timer

This block is a timer peripheral with a small register bus. It holds a free-running up-counter that advances either on every clock or on a divided tick. When the counter passes its all-ones value, it either reloads from a programmable reload register and keeps running, or it wraps to zero and stops, which gives one-shot operation. A compare register can flag the cycles in which the count equals a programmed value. Event flags are gathered in a sticky status register that software clears by writing ones. A single level interrupt is raised while any flag is set whose enable bit is also set. A soft-reset command returns every register to its reset value.

Control sits in a three-state machine. `ST_STOP` is the idle state and is entered after hard reset. `ST_RUN` is the counting state. `ST_SRST` lasts one cycle and clears the registers. The transitions are:

- `ST_STOP` goes to `ST_RUN` on a control write with the start bit set.
- `ST_RUN` goes to `ST_STOP` on a control write with the start bit clear.
- `ST_RUN` goes to `ST_STOP` on an overflow while auto-reload is off (the one-shot stop).
- `ST_STOP` or `ST_RUN` goes to `ST_SRST` on a soft-reset command.
- `ST_SRST` always goes to `ST_STOP` on the next cycle.

A software write has priority over the overflow stop. The start bit reads back as 1 exactly while the state is `ST_RUN`.

Top module: `gp_timer`

## Requirements
- R1: After hard reset, the control, counter, reload, match, enable and status registers read 0, bit 0 of the reset-status register reads 1 and `irq` is low.
- R2: The registers decode at these byte offsets: control 0x24, counter 0x28, reload 0x2C, match 0x38, status 0x18, enable 0x1C, soft-reset command 0x10, reset status 0x14. Any other offset reads 0 and ignores writes. Reads are combinational.
- R3: The control register layout is: bit 0 start, bit 1 auto-reload, bits 4:2 the prescale code p, bit 5 prescale enable, bit 6 compare enable. Writing bit 0 as 1 starts counting from the next clock. Writing it as 0 freezes the count.
- R4: With the prescaler off, the count rises by 1 on every clock after start. With it on, the count rises once every 2^(p+1) clocks. The divider restarts at every start, so after k clocks the count is floor(k / 2^(p+1)).
- R5: The counter overflows when it advances past all-ones. If auto-reload is set, the overflow loads the reload value and counting continues, so the period is (all-ones − reload) + 1 ticks. Every overflow sets status bit 1.
- R6: If auto-reload is clear, an overflow wraps the counter to 0 and clears the start bit (one-shot). The count then stays at 0.
- R7: While running with compare enable set, a cycle in which the count equals the match register sets status bit 0 on the following clock. With compare enable clear, status bit 0 is never set.
- R8: Status bits are sticky. Writing 1 to a bit of the status register clears it, and writing 0 leaves it unchanged. Bit 2 is reserved for capture and is never set.
- R9: `irq` is high exactly when (status AND enable) is non-zero.
- R10: Writing the soft-reset command with bit 1 set makes reset-status bit 0 read 0 for one cycle, then clears all registers and stops the timer. A command with bit 1 clear has no effect.
- R11: A counter write takes effect on the next clock and overrides the tick or overflow of that cycle. Counting continues from the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, combinational from `bus_addr` |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the timer with an 8-bit counter (CNT_W = 8) and the default 3-bit prescale code.

With 256 counter states, every overflow and wrap is reached within a few hundred clocks. This lets the bench sweep reload values from 0 to 255 through several full periods and run one-shot wraps to completion.

The narrow counter also keeps the prescaler sweep short. Every divider from 2 to 256 is tested, each at its boundary clock counts. Expected counts are computed arithmetically from the elapsed clocks, the divider and the reload value.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

    localparam logic [7:0] OFS_SRST_CMD = 8'h10;
    localparam logic [7:0] OFS_RST_STAT = 8'h14;
    localparam logic [7:0] OFS_ISTAT    = 8'h18;
    localparam logic [7:0] OFS_IEN      = 8'h1C;
    localparam logic [7:0] OFS_CTRL     = 8'h24;
    localparam logic [7:0] OFS_COUNT    = 8'h28;
    localparam logic [7:0] OFS_RELOAD   = 8'h2C;
    localparam logic [7:0] OFS_MATCH    = 8'h38;

    localparam int NUM_FLAGS = 3;
    localparam int FLAG_MATCH = 0;
    localparam int FLAG_OVF   = 1;
    localparam int FLAG_CAPT  = 2;

    localparam int SRST_CMD_BIT = 1;

    typedef enum logic [1:0] {
        ST_SRST = 2'd0,
        ST_STOP = 2'd1,
        ST_RUN  = 2'd2
    } gpt_state_e;

endpackage

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
    parameter int PTV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             pre_en,
    input  logic [PTV_W-1:0] ptv,
    output logic             tick
);
    localparam int DIV_W = 1 << PTV_W;

    logic [DIV_W-1:0] div_q;
    logic [PTV_W:0]   shamt;
    logic [DIV_W:0]   span;
    logic [DIV_W-1:0] last;

    always_comb begin
        shamt = {1'b0, ptv} + {{PTV_W{1'b0}}, 1'b1};
        span  = ({{DIV_W{1'b0}}, 1'b1} << shamt) - {{DIV_W{1'b0}}, 1'b1};
        last  = span[DIV_W-1:0];
        tick  = run && (!pre_en || (div_q == last));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_q <= '0;
        else if (!run || !pre_en || (div_q == last))
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end

    // R4
    div_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (div_q == '0));

endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srst,
    input  logic             tick,
    input  logic             auto_rl,
    input  logic [CNT_W-1:0] reload,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_val,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf_evt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    assign cnt     = cnt_q;
    assign ovf_evt = tick && (cnt_q == CNT_MAX) && !wr_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (srst)
            cnt_q <= '0;
        else if (wr_en)
            cnt_q <= wr_val;
        else if (ovf_evt)
            cnt_q <= auto_rl ? reload : '0;
        else if (tick)
            cnt_q <= cnt_q + 1'b1;
    end

    // R5
    reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (cnt_q == CNT_MAX) && auto_rl && !wr_en && !srst) |=> (cnt_q == $past(reload)));

    // R6
    oneshot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (cnt_q == CNT_MAX) && !auto_rl && !wr_en && !srst) |=> (cnt_q == '0));

    // R11
    direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !srst) |=> (cnt_q == $past(wr_val)));

endmodule

// File: rtl/gpt_irq_stat.sv
module gpt_irq_stat
    import gpt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 srst,
    input  logic [NUM_FLAGS-1:0] set_evt,
    input  logic                 clr_en,
    input  logic [NUM_FLAGS-1:0] clr_mask,
    input  logic [NUM_FLAGS-1:0] en,
    output logic [NUM_FLAGS-1:0] stat,
    output logic                 irq
);
    logic [NUM_FLAGS-1:0] stat_q;
    logic [NUM_FLAGS-1:0] kill;

    assign kill = clr_en ? clr_mask : '0;
    assign stat = stat_q;
    assign irq  = |(stat_q & en);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            stat_q <= '0;
        else if (srst)
            stat_q <= '0;
        else
            stat_q <= (stat_q & ~kill) | set_evt;
    end

    // R5
    ovf_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_evt[FLAG_OVF] && !srst) |=> stat_q[FLAG_OVF]);

    // R8
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && clr_mask[FLAG_OVF] && !set_evt[FLAG_OVF]) |=> !stat_q[FLAG_OVF]);

    // R8
    zero_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[FLAG_OVF] && !kill[FLAG_OVF] && !srst) |=> stat_q[FLAG_OVF]);

endmodule

// File: rtl/gp_timer.sv
module gp_timer
    import gpt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PTV_W  = 3,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);
    localparam int PTV_LO  = 2;
    localparam int PTV_HI  = PTV_LO + PTV_W - 1;
    localparam int PRE_POS = PTV_W + 2;
    localparam int CMP_POS = PTV_W + 3;
    localparam int CTRL_W  = PTV_W + 4;

    gpt_state_e state_q, state_d;

    logic                 ar_q, pre_q, cmp_q;
    logic [PTV_W-1:0]     ptv_q;
    logic [NUM_FLAGS-1:0] ien_q;
    logic [CNT_W-1:0]     reload_q, match_q;

    logic running, in_srst, rst_done;
    logic hit_srst, hit_rstat, hit_istat, hit_ien, hit_ctrl, hit_cnt, hit_rel, hit_match;
    logic wr_ok, srst_req;
    logic tick, ovf_evt, match_evt;
    logic [CNT_W-1:0]     cnt;
    logic [NUM_FLAGS-1:0] stat, set_evt;

    always_comb begin
        hit_srst  = (bus_addr == ADDR_W'(OFS_SRST_CMD));
        hit_rstat = (bus_addr == ADDR_W'(OFS_RST_STAT));
        hit_istat = (bus_addr == ADDR_W'(OFS_ISTAT));
        hit_ien   = (bus_addr == ADDR_W'(OFS_IEN));
        hit_ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
        hit_cnt   = (bus_addr == ADDR_W'(OFS_COUNT));
        hit_rel   = (bus_addr == ADDR_W'(OFS_RELOAD));
        hit_match = (bus_addr == ADDR_W'(OFS_MATCH));
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_STOP;
        else
            state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SRST: state_d = ST_STOP;
            ST_STOP, ST_RUN: begin
                if (srst_req)
                    state_d = ST_SRST;
                else if (wr_ok && hit_ctrl)
                    state_d = bus_wdata[0] ? ST_RUN : ST_STOP;
                else if ((state_q == ST_RUN) && ovf_evt && !ar_q)
                    state_d = ST_STOP;
            end
            default: state_d = ST_STOP;
        endcase
    end

    // State-decoded outputs
    always_comb begin
        running  = (state_q == ST_RUN);
        in_srst  = (state_q == ST_SRST);
        rst_done = !in_srst;
        wr_ok    = bus_sel && bus_wr && !in_srst;
        srst_req = wr_ok && hit_srst && bus_wdata[SRST_CMD_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ar_q     <= 1'b0;
            pre_q    <= 1'b0;
            cmp_q    <= 1'b0;
            ptv_q    <= '0;
            ien_q    <= '0;
            reload_q <= '0;
            match_q  <= '0;
        end else if (in_srst) begin
            ar_q     <= 1'b0;
            pre_q    <= 1'b0;
            cmp_q    <= 1'b0;
            ptv_q    <= '0;
            ien_q    <= '0;
            reload_q <= '0;
            match_q  <= '0;
        end else if (wr_ok) begin
            if (hit_ctrl) begin
                ar_q  <= bus_wdata[1];
                ptv_q <= bus_wdata[PTV_HI:PTV_LO];
                pre_q <= bus_wdata[PRE_POS];
                cmp_q <= bus_wdata[CMP_POS];
            end
            if (hit_ien)   ien_q    <= bus_wdata[NUM_FLAGS-1:0];
            if (hit_rel)   reload_q <= bus_wdata;
            if (hit_match) match_q  <= bus_wdata;
        end
    end

    gpt_prescaler #(.PTV_W(PTV_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (running),
        .pre_en (pre_q),
        .ptv    (ptv_q),
        .tick   (tick)
    );

    gpt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .srst    (in_srst),
        .tick    (tick),
        .auto_rl (ar_q),
        .reload  (reload_q),
        .wr_en   (wr_ok && hit_cnt),
        .wr_val  (bus_wdata),
        .cnt     (cnt),
        .ovf_evt (ovf_evt)
    );

    assign match_evt = running && cmp_q && (cnt == match_q);
    assign set_evt   = {1'b0, ovf_evt, match_evt};

    gpt_irq_stat u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .srst     (in_srst),
        .set_evt  (set_evt),
        .clr_en   (wr_ok && hit_istat),
        .clr_mask (bus_wdata[NUM_FLAGS-1:0]),
        .en       (ien_q),
        .stat     (stat),
        .irq      (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            if (hit_ctrl)
                bus_rdata[CTRL_W-1:0] = {cmp_q, pre_q, ptv_q, ar_q, running};
            else if (hit_cnt)
                bus_rdata = cnt;
            else if (hit_rel)
                bus_rdata = reload_q;
            else if (hit_match)
                bus_rdata = match_q;
            else if (hit_istat)
                bus_rdata[NUM_FLAGS-1:0] = stat;
            else if (hit_ien)
                bus_rdata[NUM_FLAGS-1:0] = ien_q;
            else if (hit_rstat)
                bus_rdata[0] = rst_done;
        end
    end

    // R10
    srst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_srst |=> (state_q == ST_STOP && reload_q == '0 && match_q == '0 && ien_q == '0 && cnt == '0));

    // R6
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && ovf_evt && !ar_q && !(wr_ok && (hit_ctrl || hit_srst))) |=> (state_q == ST_STOP));

    // R3
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && hit_ctrl && bus_wdata[0]) |=> (state_q == ST_RUN));

    // R7
    cmp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_q && !stat[FLAG_MATCH] && !in_srst) |=> !stat[FLAG_MATCH]);

endmodule

// File: tb/sim_gp_timer.sv
`timescale 1ns/1ps
module sim_gp_timer;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_sel = 1'b0;
    logic         bus_wr = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         irq;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    gp_timer #(.CNT_W(W), .PTV_W(3), .ADDR_W(8)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    localparam logic [7:0] A_SRST = 8'h10, A_RST = 8'h14, A_IST = 8'h18, A_IEN = 8'h1C;
    localparam logic [7:0] A_CTL = 8'h24, A_CNT = 8'h28, A_REL = 8'h2C, A_MAT = 8'h38;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input int d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = W'(d);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int v);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        v = int'(bus_rdata);
        bus_sel = 1'b0;
    endtask

    task automatic wait_cyc(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int v;
        int per;
        int kl[5];
        int rl[6];
        int d;

        wait_cyc(3);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        rd(A_CTL, v); check("R1 ctrl", v, 0);
        rd(A_CNT, v); check("R1 count", v, 0);
        rd(A_REL, v); check("R1 reload", v, 0);
        rd(A_MAT, v); check("R1 match", v, 0);
        rd(A_IST, v); check("R1 status", v, 0);
        rd(A_IEN, v); check("R1 enable", v, 0);
        rd(A_RST, v); check("R1 reset done", v, 1);
        check("R1 irq", int'(irq), 0);

        // R2 readback and unmapped offsets
        wr(A_REL, 8'h5A); wr(A_MAT, 8'hA5); wr(A_IEN, 7); wr(8'h00, 8'hFF);
        rd(A_REL, v); check("R2 reload", v, 8'h5A);
        rd(A_MAT, v); check("R2 match", v, 8'hA5);
        rd(A_IEN, v); check("R2 enable", v, 7);
        rd(8'h00, v); check("R2 unmapped", v, 0);
        rd(8'h20, v); check("R2 unmapped 20", v, 0);
        wr(A_IEN, 0); wr(A_MAT, 0);

        // R3 plain counting sweep
        for (int k = 0; k <= 20; k++) begin
            wr(A_CTL, 0); wr(A_CNT, 0); wr(A_CTL, 1);
            wait_cyc(k);
            rd(A_CNT, v); check("R3 count", v, k);
        end
        wr(A_CTL, 0);
        rd(A_CNT, v); wait_cyc(5);
        begin int v2; rd(A_CNT, v2); check("R3 frozen", v2, v); end
        rd(A_CTL, v); check("R3 start bit low", v, 0);

        // R4 prescaler sweep over every code
        for (int p = 0; p < 8; p++) begin
            d = 1 << (p + 1);
            kl[0] = 0; kl[1] = d - 1; kl[2] = d; kl[3] = 2 * d + 1; kl[4] = 3 * d - 1;
            for (int j = 0; j < 5; j++) begin
                wr(A_CTL, 0); wr(A_CNT, 0);
                wr(A_CTL, 1 | (1 << 5) | (p << 2));
                wait_cyc(kl[j]);
                rd(A_CNT, v); check("R4 prescaled count", v, (kl[j] / d) % 256);
            end
        end
        wr(A_CTL, 0);

        // R5 auto-reload sweep
        rl[0] = 0; rl[1] = 1; rl[2] = 100; rl[3] = 200; rl[4] = 254; rl[5] = 255;
        for (int r = 0; r < 6; r++) begin
            per = 256 - rl[r];
            kl[0] = 1; kl[1] = per - 1; kl[2] = per; kl[3] = per + 1; kl[4] = 2 * per + 3;
            for (int j = 0; j < 5; j++) begin
                wr(A_CTL, 0); wr(A_REL, rl[r]); wr(A_CNT, rl[r]); wr(A_IST, 7);
                wr(A_CTL, 3);
                wait_cyc(kl[j]);
                rd(A_CNT, v); check("R5 reload count", v, rl[r] + (kl[j] % per));
                rd(A_IST, v); check("R5 overflow flag", (v >> 1) & 1, (kl[j] >= per) ? 1 : 0);
                rd(A_CTL, v); check("R5 still running", v & 1, 1);
            end
        end
        wr(A_CTL, 0); wr(A_REL, 0); wr(A_IST, 7);

        // R6 one-shot
        wr(A_CNT, 250); wr(A_CTL, 1);
        wait_cyc(5);
        rd(A_CNT, v); check("R6 at top", v, 255);
        rd(A_IST, v); check("R6 no flag yet", v, 0);
        wait_cyc(1);
        rd(A_CNT, v); check("R6 wrapped", v, 0);
        rd(A_CTL, v); check("R6 start cleared", v & 1, 0);
        wait_cyc(10);
        rd(A_CNT, v); check("R6 stays 0", v, 0);

        // R9 and R8 interrupt and write-one-to-clear
        rd(A_IST, v); check("R8 overflow sticky", v, 2);
        check("R9 irq masked", int'(irq), 0);
        wr(A_IEN, 2);
        check("R9 irq raised", int'(irq), 1);
        wr(A_IST, 5);
        rd(A_IST, v); check("R8 zero write keeps", v, 2);
        check("R9 irq held", int'(irq), 1);
        wr(A_IST, 2);
        rd(A_IST, v); check("R8 cleared", v, 0);
        check("R9 irq dropped", int'(irq), 0);
        wr(A_IEN, 0);

        // R7 compare match
        wr(A_MAT, 10); wr(A_CNT, 0); wr(A_CTL, 8'h41);
        wait_cyc(10);
        rd(A_CNT, v); check("R7 count at match", v, 10);
        rd(A_IST, v); check("R7 not yet", v & 1, 0);
        wait_cyc(1);
        rd(A_IST, v); check("R7 match flag", v & 1, 1);
        check("R8 capture bit never set", (v >> 2) & 1, 0);
        wr(A_IEN, 1);
        check("R9 irq on match", int'(irq), 1);
        wr(A_CTL, 0); wr(A_IST, 7); wr(A_IEN, 0); wr(A_CNT, 0);
        wr(A_CTL, 1);
        wait_cyc(15);
        rd(A_IST, v); check("R7 compare disabled", v & 1, 0);

        // R11 direct write while running
        wr(A_CNT, 100);
        rd(A_CNT, v); check("R11 written value", v, 100);
        wait_cyc(1);
        rd(A_CNT, v); check("R11 continues", v, 101);

        // R10 soft reset
        wr(A_REL, 33); wr(A_MAT, 44); wr(A_IEN, 3);
        wr(A_SRST, 1);
        rd(A_CTL, v); check("R10 bit1 clear no effect", v & 1, 1);
        rd(A_REL, v); check("R10 reload kept", v, 33);
        wr(A_SRST, 2);
        rd(A_RST, v); check("R10 in progress", v, 0);
        wait_cyc(1);
        rd(A_RST, v); check("R10 done", v, 1);
        rd(A_CTL, v); check("R10 ctrl", v, 0);
        rd(A_REL, v); check("R10 reload", v, 0);
        rd(A_MAT, v); check("R10 match", v, 0);
        rd(A_IEN, v); check("R10 enable", v, 0);
        rd(A_CNT, v); check("R10 count", v, 0);
        rd(A_IST, v); check("R10 status", v, 0);
        wait_cyc(4);
        rd(A_CNT, v); check("R10 stopped", v, 0);

        summary();
        $finish;
    end
endmodule